// File: doc/BRIEF.md
# Link-Training Hold-Off Controller

This block sits beside the controller core of a PCIe-style endpoint and decides when the link-training enable reaches that core. Firmware controls it through a small register port. The main feature is an optional automatic hold. When the hold is armed, every hot reset or link-down reset request parks the block in a holding state, and link training stays off. While training is off, firmware can rewrite configuration registers without racing a new training attempt. Firmware then issues a one-shot "done" command, which lets training start again.

The control register and the interrupt-enable register are written in a masked form. The upper 16 bits of the write data select which of the lower 16 bits change. An interrupt status register records reset requests and link-state-change events. Firmware clears its bits by writing a 1 to them. The interrupt output is raised while any recorded event is also enabled.

The hold logic is a two-state machine. RUN means training may proceed. HOLD means training is inhibited. It has three transitions:
- RUN to HOLD (ARM_HIT) happens on a reset request while the hold is armed.
- HOLD to RUN (RELEASE) happens on a "done" command when no reset request arrives in the same cycle.
- Every other case stays in the current state (STAY).

Top module: `lnk_train_gate`

## Requirements
- R1: After power-on reset, every register reads 0: the control register at 0x180, the status register at 0x010 and the interrupt-enable register at 0x014. The interrupt output is low and the machine is in RUN.
- R2: A write to the control register or the interrupt-enable register changes lower bit i only when bit 16+i of the write data is 1. Every other bit keeps its value.
- R3: The control register reads back bit 1 (hold armed) and bit 4 (enhanced mode). Bit 3 (done command) always reads 0, and all other bits read 0.
- R4: With enhanced mode (bit 4) clear, the training-enable output equals the application enable input, whatever the hold state or core reset.
- R5: With the hold armed and enhanced mode set, a reset request seen at a clock edge moves the machine to HOLD (ARM_HIT). The training-enable output is low from that edge on, with no firmware action.
- R6: In HOLD, a control write with bit 3 and mask bit 19 both set returns the machine to RUN (RELEASE) at that edge. Training enable then follows the application enable again.
- R7: A done command has no effect when the machine is in RUN. A write that sets bit 3 without mask bit 19 is never a done command.
- R8: With the hold armed bit clear, a reset request leaves the machine in RUN, and training enable stays high.
- R9: Status bit 0 is set by a reset request and status bit 1 by a link-state-change event. Writing 1 to a status bit at 0x010 clears it, and writing 0 leaves it unchanged.
- R10: The interrupt output is high exactly when some status bit and its matching bit in the interrupt-enable register are both 1.
- R11: An event that arrives in the same cycle as a clearing write to its status bit leaves that bit set.
- R12: With enhanced mode set, training enable is low while the core reset input (active low) is asserted.
- R13: A reset request in the same cycle as a done command, while in HOLD, keeps the machine in HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data (masked format for control and enable) |
| reg_rdata | output | 32 | Read data for reg_addr |
| hot_rst_req | input | 1 | Single-cycle hot reset or link-down reset request |
| link_chg_evt | input | 1 | Single-cycle link-state-change event |
| core_rst_n | input | 1 | Core reset sequencing, active low |
| app_train_en | input | 1 | Application training enable |
| train_en | output | 1 | Training enable toward the controller core |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The hardest conditions to reach are the same-cycle collisions. The first is a reset request that lands on the same edge as a done command while in HOLD. The second is an event that lands on the same edge as a write that clears its own status bit. The bench reaches both with a write task that can also pulse an event input in the same cycle as the strobe. It then watches train_en and reads back the status register on the following cycle. A third condition is easy to miss: a done command that is ignored in RUN. The bench shows this by issuing the command in RUN and then confirming that a later reset request still holds the link.

// File: rtl/train_gate_pkg.sv
package train_gate_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } hold_st_t;

    localparam int HALF_W    = 16;
    localparam int BIT_ARM   = 1;
    localparam int BIT_DONE  = 3;
    localparam int BIT_ENH   = 4;
    localparam logic [HALF_W-1:0] CTRL_IMPL =
        HALF_W'((1 << BIT_ARM) | (1 << BIT_ENH));

    function automatic logic [HALF_W-1:0] masked_upd(
        input logic [HALF_W-1:0]   old_v,
        input logic [2*HALF_W-1:0] wd
    );
        logic [HALF_W-1:0] m;
        m = wd[2*HALF_W-1:HALF_W];
        return (old_v & ~m) | (wd[HALF_W-1:0] & m);
    endfunction

endpackage

// File: rtl/tg_ctrl_reg.sv
module tg_ctrl_reg
    import train_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [31:0]       wdata,
    output logic [HALF_W-1:0] ctrl_q,
    output logic              arm_en,
    output logic              enh_en,
    output logic              done_cmd
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_sel)
            ctrl_q <= masked_upd(ctrl_q, wdata) & CTRL_IMPL;
    end

    assign arm_en   = ctrl_q[BIT_ARM];
    assign enh_en   = ctrl_q[BIT_ENH];
    assign done_cmd = wr_sel && wdata[HALF_W+BIT_DONE] && wdata[BIT_DONE];
endmodule

// File: rtl/tg_irq_stat.sv
module tg_irq_stat #(
    parameter int STAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt,
    input  logic              stat_wr,
    input  logic              ien_wr,
    input  logic [STAT_W-1:0] wd_lo,
    input  logic [STAT_W-1:0] wd_hi,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] ien_q,
    output logic              irq
);
    logic [STAT_W-1:0] clr;

    assign clr = stat_wr ? wd_lo : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr) | evt;
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_ien
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ien_q[i] <= 1'b0;
            else if (ien_wr && wd_hi[i])
                ien_q[i] <= wd_lo[i];
        end
    end

    assign irq = |(stat_q & ien_q);
endmodule

// File: rtl/tg_hold_fsm.sv
module tg_hold_fsm
    import train_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rst_req,
    input  logic     arm_en,
    input  logic     done_cmd,
    input  logic     enh_en,
    input  logic     core_rst_n,
    input  logic     app_en,
    output hold_st_t st_q,
    output logic     train_en
);
    hold_st_t st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  if (rst_req && arm_en) st_d = ST_HOLD;
            ST_HOLD: if (done_cmd && !(rst_req && arm_en)) st_d = ST_RUN;
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_RUN;
        else
            st_q <= st_d;
    end

    always_comb begin
        if (!enh_en)
            train_en = app_en;
        else
            train_en = app_en && core_rst_n && (st_q == ST_RUN);
    end
endmodule

// File: rtl/lnk_train_gate.sv
module lnk_train_gate
    import train_gate_pkg::*;
#(
    parameter int              AW       = 12,
    parameter int              STAT_W   = 2,
    parameter logic [AW-1:0]   CTRL_OFS = 12'h180,
    parameter logic [AW-1:0]   STAT_OFS = 12'h010,
    parameter logic [AW-1:0]   IEN_OFS  = 12'h014
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          hot_rst_req,
    input  logic          link_chg_evt,
    input  logic          core_rst_n,
    input  logic          app_train_en,
    output logic          train_en,
    output logic          irq
);
    logic              ctrl_sel, stat_sel, ien_sel;
    logic [HALF_W-1:0] ctrl_q;
    logic              arm_en, enh_en, done_cmd;
    logic [STAT_W-1:0] stat_q, ien_q, evt_vec;
    hold_st_t          fsm_st;

    assign ctrl_sel = reg_wr && (reg_addr == CTRL_OFS);
    assign stat_sel = reg_wr && (reg_addr == STAT_OFS);
    assign ien_sel  = reg_wr && (reg_addr == IEN_OFS);

    always_comb begin
        evt_vec    = '0;
        evt_vec[0] = hot_rst_req;
        if (STAT_W > 1) evt_vec[STAT_W-1] = link_chg_evt;
    end

    tg_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (ctrl_sel),
        .wdata    (reg_wdata),
        .ctrl_q   (ctrl_q),
        .arm_en   (arm_en),
        .enh_en   (enh_en),
        .done_cmd (done_cmd)
    );

    tg_irq_stat #(.STAT_W(STAT_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_vec),
        .stat_wr (stat_sel),
        .ien_wr  (ien_sel),
        .wd_lo   (reg_wdata[STAT_W-1:0]),
        .wd_hi   (reg_wdata[HALF_W+STAT_W-1:HALF_W]),
        .stat_q  (stat_q),
        .ien_q   (ien_q),
        .irq     (irq)
    );

    tg_hold_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_req    (hot_rst_req),
        .arm_en     (arm_en),
        .done_cmd   (done_cmd),
        .enh_en     (enh_en),
        .core_rst_n (core_rst_n),
        .app_en     (app_train_en),
        .st_q       (fsm_st),
        .train_en   (train_en)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_OFS)
            reg_rdata[HALF_W-1:0] = ctrl_q;
        else if (reg_addr == STAT_OFS)
            reg_rdata[STAT_W-1:0] = stat_q;
        else if (reg_addr == IEN_OFS)
            reg_rdata[STAT_W-1:0] = ien_q;
    end
endmodule

// File: rtl/train_gate_chk.sv
module train_gate_chk #(
    parameter int STAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_req,
    input logic              arm_en,
    input logic              enh_en,
    input logic              done_cmd,
    input logic              in_hold,
    input logic              core_rst_n,
    input logic              train_en,
    input logic [STAT_W-1:0] stat_q,
    input logic              irq
);
    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && arm_en) |=> in_hold); // R5

    AST_HOLD_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && enh_en) |-> !train_en); // R5

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && done_cmd && !rst_req) |=> !in_hold); // R6

    AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_hold && !(rst_req && arm_en)) |=> !in_hold); // R7

    AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && rst_req && arm_en) |=> in_hold); // R13

    AST_CORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_en && !core_rst_n) |-> !train_en); // R12

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq); // R10

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> stat_q[0]); // R11
endmodule

bind lnk_train_gate train_gate_chk #(.STAT_W(STAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req    (hot_rst_req),
    .arm_en     (arm_en),
    .enh_en     (enh_en),
    .done_cmd   (done_cmd),
    .in_hold    (fsm_st == train_gate_pkg::ST_HOLD),
    .core_rst_n (core_rst_n),
    .train_en   (train_en),
    .stat_q     (stat_q),
    .irq        (irq)
);

// File: tb/test_lnk_train_gate.sv
`timescale 1ns/1ps
module test_lnk_train_gate;
    localparam logic [11:0] A_CTRL = 12'h180;
    localparam logic [11:0] A_STAT = 12'h010;
    localparam logic [11:0] A_IEN  = 12'h014;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hot_rst_req = 1'b0;
    logic        link_chg_evt = 1'b0;
    logic        core_rst_n = 1'b1;
    logic        app_train_en = 1'b1;
    logic        train_en, irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lnk_train_gate i_lnk_train_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .hot_rst_req  (hot_rst_req),
        .link_chg_evt (link_chg_evt),
        .core_rst_n   (core_rst_n),
        .app_train_en (app_train_en),
        .train_en     (train_en),
        .irq          (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // write on one edge, optionally pulsing events on the same edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d,
                      input logic ev_rst = 1'b0, input logic ev_lnk = 1'b0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        hot_rst_req = ev_rst; link_chg_evt = ev_lnk;
        @(negedge clk);
        reg_wr = 1'b0; hot_rst_req = 1'b0; link_chg_evt = 1'b0;
    endtask

    task automatic pulse(input logic ev_rst, input logic ev_lnk);
        @(negedge clk);
        hot_rst_req = ev_rst; link_chg_evt = ev_lnk;
        @(negedge clk);
        hot_rst_req = 1'b0; link_chg_evt = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", A_CTRL, 32'h0);
        rd_chk("R1 stat", A_STAT, 32'h0);
        rd_chk("R1 ien", A_IEN, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 train_en", {31'b0, train_en}, 32'h1);
    endtask

    task automatic t_mask;
        wr(A_CTRL, 32'h0000_0012);
        rd_chk("R2 unmasked write ignored", A_CTRL, 32'h0);
        wr(A_CTRL, 32'h0012_0012);
        rd_chk("R3 readback arm+enh", A_CTRL, 32'h12);
        wr(A_CTRL, 32'h0008_0008);
        rd_chk("R3 done reads 0", A_CTRL, 32'h12);
        wr(A_CTRL, 32'h0002_0000);
        rd_chk("R2 only masked bit cleared", A_CTRL, 32'h10);
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd_chk("R3 unimplemented bits read 0", A_CTRL, 32'h12);
        wr(A_CTRL, 32'h0002_0000);
    endtask

    task automatic t_bypass;
        wr(A_CTRL, 32'h0010_0000);
        app_train_en = 1'b0; #1;
        chk("R4 follows app low", {31'b0, train_en}, 32'h0);
        app_train_en = 1'b1; #1;
        chk("R4 follows app high", {31'b0, train_en}, 32'h1);
        core_rst_n = 1'b0; #1;
        chk("R4 core reset bypassed", {31'b0, train_en}, 32'h1);
        core_rst_n = 1'b1;
    endtask

    task automatic t_hold;
        wr(A_CTRL, 32'h0012_0012);
        chk("R5 before event", {31'b0, train_en}, 32'h1);
        pulse(1'b1, 1'b0);
        chk("R5 hold after event", {31'b0, train_en}, 32'h0);
        repeat (4) @(negedge clk);
        chk("R5 hold persists", {31'b0, train_en}, 32'h0);
        wr(A_CTRL, 32'h0000_0008);
        chk("R7 done without mask", {31'b0, train_en}, 32'h0);
        wr(A_CTRL, 32'h0008_0008, 1'b1);
        chk("R13 event beats done", {31'b0, train_en}, 32'h0);
        wr(A_CTRL, 32'h0008_0008);
        chk("R6 release", {31'b0, train_en}, 32'h1);
        wr(A_CTRL, 32'h0008_0008);
        chk("R7 done in RUN no effect", {31'b0, train_en}, 32'h1);
        pulse(1'b1, 1'b0);
        chk("R7 later event still holds", {31'b0, train_en}, 32'h0);
        wr(A_CTRL, 32'h0008_0008);
        chk("R6 second release", {31'b0, train_en}, 32'h1);
    endtask

    task automatic t_nodelay;
        wr(A_CTRL, 32'h0002_0000);
        pulse(1'b1, 1'b0);
        chk("R8 no hold when unarmed", {31'b0, train_en}, 32'h1);
        repeat (3) @(negedge clk);
        chk("R8 still running", {31'b0, train_en}, 32'h1);
    endtask

    task automatic t_core;
        core_rst_n = 1'b0; #1;
        chk("R12 core reset gates", {31'b0, train_en}, 32'h0);
        core_rst_n = 1'b1; #1;
        chk("R12 core reset released", {31'b0, train_en}, 32'h1);
    endtask

    task automatic t_irq;
        rd_chk("R9 reset request recorded", A_STAT, 32'h1);
        chk("R10 masked irq low", {31'b0, irq}, 32'h0);
        wr(A_STAT, 32'h0000_0001);
        rd_chk("R9 w1c clears", A_STAT, 32'h0);
        wr(A_IEN, 32'h0003_0001);
        rd_chk("R2 ien masked write", A_IEN, 32'h1);
        pulse(1'b1, 1'b0);
        chk("R10 irq raised", {31'b0, irq}, 32'h1);
        pulse(1'b0, 1'b1);
        rd_chk("R9 link change bit", A_STAT, 32'h3);
        wr(A_STAT, 32'h0000_0001);
        rd_chk("R9 write 0 keeps bit", A_STAT, 32'h2);
        chk("R10 disabled bit no irq", {31'b0, irq}, 32'h0);
        wr(A_STAT, 32'h0000_0001, 1'b1);
        rd_chk("R11 event wins over clear", A_STAT, 32'h3);
        chk("R11 irq after collision", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h0000_0003);
        rd_chk("R9 all cleared", A_STAT, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_bypass();
        t_hold();
        t_nodelay();
        t_core();
        t_irq();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule